// File: doc/BRIEF.md
# Pipelined Data Tenure Scheduler

This block sits in a bus interface unit whose address bus runs ahead of its data bus. Each address phase that finishes pushes one pending data tenure into a small ordered queue. The tenure is tagged as a read or a write, as a single beat or a burst, and carries an identifier. When the block sees a qualified data-bus grant, it removes one queued tenure and becomes the data-bus owner. It drives an active-low busy output while it owns the bus. It counts transfer acknowledges and retires the tenure after the last one.

A write-priority hint is sampled only on the grant cycle. When the hint is set and a write is waiting, the oldest waiting write goes ahead of any older reads, but never ahead of another write. With the hint clear, or with no write waiting, tenures run strictly in address order. A data retry on the cycle after the final acknowledge cancels that beat. The block then keeps ownership until the beat is acknowledged again.

Top module: `dts_sched`

## Requirements
- R1: While reset is active and right after it, busy_n is 1, q_full is 0, retire_valid is 0 and act_valid is 0.
- R2: With wr_first low at the grant, the tenure taken is always the oldest queued one, so reads and writes run in push order.
- R3: With wr_first high at the grant and at least one write queued, the tenure taken is the oldest queued write, even when older reads are queued.
- R4: Writes never overtake one another. The write taken is always the oldest queued write, so writes retire in push order.
- R5: With wr_first high at the grant and no write queued, the hint is ignored and the oldest queued read is taken.
- R6: wr_first is sampled only in the cycle of a qualified grant. Its value in any other cycle does not change which tenure is taken.
- R7: A grant is qualified when grant is 1, ext_busy is 0, the queue is not empty and the block is not already owner. On the clock edge of a qualified grant, the block takes ownership: busy_n is 0 and act_tag shows the taken tenure from the next cycle on. A grant while ext_busy is 1 is not taken.
- R8: A single tenure (push_burst=0) needs 1 acknowledge and a burst (push_burst=1) needs 4. In the cycle after the final acknowledge, retire_valid is 1 with retire_tag equal to the tenure's tag, provided data_retry is 0.
- R9: data_retry high in the cycle after the final acknowledge cancels that beat. retire_valid stays 0, busy_n stays 0, and the block waits with no time limit for one more acknowledge before it retires.
- R10: busy_n returns to 1 in the cycle after retirement. A grant with an empty queue leaves busy_n at 1.
- R11: The queue holds 4 entries. q_full is 1 when 4 are queued, and a push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | An address phase finished; enqueue its data tenure |
| push_write | input | 1 | 1 = write tenure, 0 = read |
| push_burst | input | 1 | 1 = 4-beat burst, 0 = single beat |
| push_tag | input | 4 | Identifier of the pushed tenure |
| q_full | output | 1 | Queue full; the address side must stall |
| grant | input | 1 | Data-bus grant from the arbiter |
| ext_busy | input | 1 | Data bus still held by another master |
| wr_first | input | 1 | Write-priority hint, sampled at the qualified grant |
| xfer_ack | input | 1 | Transfer acknowledge for one data beat |
| data_retry | input | 1 | Cancels the final beat when high in the cycle after it |
| busy_n | output | 1 | Active-low data-bus busy, 0 while owner |
| act_valid | output | 1 | A tenure is active |
| act_write | output | 1 | Active tenure is a write |
| act_tag | output | 4 | Identifier of the active tenure |
| retire_valid | output | 1 | Active tenure completes this cycle |
| retire_tag | output | 4 | Identifier of the completing tenure |

## Verification
The bench builds the block with its defaults: a queue depth of 4, a burst of 4 beats and 4-bit tags. This is enough to fill the queue, to drop a push while it is full, and to mix older reads with two waiting writes. The hint can then be seen to pick the first write, then the second, and then to fall back to the read order once only reads remain. A four-beat burst lets the bench watch the tenure stay open across intermediate acknowledges. The single-beat tenures allow the retry of a last-and-only beat to be tested.

// File: rtl/dts_pkg.sv
package dts_pkg;

  localparam int TAG_W = 4;

  typedef struct packed {
    logic             write;
    logic             burst;
    logic [TAG_W-1:0] tag;
  } ent_t;

  typedef enum logic [1:0] {
    T_IDLE = 2'd0,
    T_XFER = 2'd1,
    T_CHK  = 2'd2
  } ten_st_t;

endpackage

// File: rtl/dts_queue.sv
module dts_queue #(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_en,
  input  dts_pkg::ent_t                 push_ent,
  input  logic                          pop_en,
  input  logic [IDX_W-1:0]              pop_idx,
  output dts_pkg::ent_t [DEPTH-1:0]     q_ent,
  output logic [DEPTH-1:0]              q_vld,
  output logic [CNT_W-1:0]              q_cnt
);

  dts_pkg::ent_t [DEPTH-1:0] ent_q, ent_d;
  logic [CNT_W-1:0]          cnt_q, cnt_d, cnt_mid;
  logic                      upd_en;

  assign upd_en = push_en | pop_en;

  // Next state: compact over the removed slot, then append at the tail.
  always_comb begin
    ent_d   = ent_q;
    cnt_mid = cnt_q;
    if (pop_en) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= pop_idx) ent_d[i] = ent_q[i+1];
      end
      cnt_mid = cnt_q - CNT_W'(1);
    end
    cnt_d = cnt_mid;
    if (push_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == cnt_mid) ent_d[i] = push_ent;
      end
      cnt_d = cnt_mid + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      ent_q <= ent_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
      assign q_vld[g] = (CNT_W'(g) < cnt_q);
    end
  endgenerate

  assign q_ent = ent_q;
  assign q_cnt = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R11

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(DEPTH) && !pop_en) |=> (cnt_q == CNT_W'(DEPTH))); // R11

endmodule

// File: rtl/dts_pick.sv
module dts_pick #(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  dts_pkg::ent_t [DEPTH-1:0] q_ent,
  input  logic [DEPTH-1:0]          q_vld,
  input  logic                      hint,
  output logic [IDX_W-1:0]          sel_idx,
  output logic                      wr_found
);

  logic [DEPTH-1:0] wr_mask;
  logic [IDX_W-1:0] wr_idx;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_wr
      assign wr_mask[g] = q_vld[g] & q_ent[g].write;
    end
  endgenerate

  // Lowest-index (oldest) write wins.
  always_comb begin
    wr_idx   = '0;
    wr_found = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (wr_mask[i]) begin
        wr_idx   = IDX_W'(i);
        wr_found = 1'b1;
      end
    end
  end

  assign sel_idx = (hint && wr_found) ? wr_idx : '0;

endmodule

// File: rtl/dts_tenure.sv
module dts_tenure #(
  parameter int BURST_LEN = 4,
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  dts_pkg::ent_t                 start_ent,
  input  logic                          xfer_ack,
  input  logic                          data_retry,
  output logic                          idle,
  output logic                          busy_n,
  output dts_pkg::ent_t                 act_ent,
  output logic                          retire_valid,
  output logic [dts_pkg::TAG_W-1:0]     retire_tag
);

  import dts_pkg::*;

  ten_st_t           st_q, st_d;
  logic [BEAT_W-1:0] beat_q, beat_d, beat_last;
  ent_t              act_q, act_d;
  logic              busy_n_q, busy_n_d;
  logic              act_en;

  assign beat_last = act_q.burst ? BEAT_W'(BURST_LEN - 1) : '0;
  assign act_en    = start && (st_q == T_IDLE);

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    act_d  = act_en ? start_ent : act_q;
    unique case (st_q)
      T_IDLE: begin
        if (start) begin
          st_d   = T_XFER;
          beat_d = '0;
        end
      end
      T_XFER: begin
        if (xfer_ack) begin
          if (beat_q == beat_last) st_d = T_CHK;
          else                     beat_d = beat_q + BEAT_W'(1);
        end
      end
      T_CHK: begin
        if (data_retry) st_d = T_XFER;
        else            st_d = T_IDLE;
      end
      default: st_d = T_IDLE;
    endcase
    busy_n_d = (st_d == T_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= T_IDLE;
      beat_q   <= '0;
      busy_n_q <= 1'b1;
    end else begin
      st_q     <= st_d;
      beat_q   <= beat_d;
      busy_n_q <= busy_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_en) act_q <= act_d;
  end

  assign idle         = (st_q == T_IDLE);
  assign busy_n       = busy_n_q;
  assign act_ent      = act_q;
  assign retire_valid = (st_q == T_CHK) && !data_retry;
  assign retire_tag   = act_q.tag;

  AST_TAKE_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |=> !busy_n); // R7

  AST_RETIRE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> $past(xfer_ack)); // R8

  AST_RETRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == T_CHK) && data_retry) |=> (!busy_n && !retire_valid)); // R9

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> busy_n); // R10

endmodule

// File: rtl/dts_sched.sv
module dts_sched #(
  parameter int DEPTH     = 4,
  parameter int BURST_LEN = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push_valid,
  input  logic                      push_write,
  input  logic                      push_burst,
  input  logic [dts_pkg::TAG_W-1:0] push_tag,
  output logic                      q_full,
  input  logic                      grant,
  input  logic                      ext_busy,
  input  logic                      wr_first,
  input  logic                      xfer_ack,
  input  logic                      data_retry,
  output logic                      busy_n,
  output logic                      act_valid,
  output logic                      act_write,
  output logic [dts_pkg::TAG_W-1:0] act_tag,
  output logic                      retire_valid,
  output logic [dts_pkg::TAG_W-1:0] retire_tag
);

  import dts_pkg::*;

  ent_t [DEPTH-1:0] q_ent;
  logic [DEPTH-1:0] q_vld;
  logic [CNT_W-1:0] q_cnt;
  logic [IDX_W-1:0] sel_idx;
  logic             wr_found;
  logic             ten_idle;
  logic             push_en;
  logic             qual_grant;
  ent_t             push_ent;
  ent_t             act_ent;

  assign q_full     = (q_cnt == CNT_W'(DEPTH));
  assign push_en    = push_valid && !q_full;
  assign qual_grant = grant && !ext_busy && (q_cnt != '0) && ten_idle;

  always_comb begin
    push_ent       = '0;
    push_ent.write = push_write;
    push_ent.burst = push_burst;
    push_ent.tag   = push_tag;
  end

  dts_queue #(.DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_en  (push_en),
    .push_ent (push_ent),
    .pop_en   (qual_grant),
    .pop_idx  (sel_idx),
    .q_ent    (q_ent),
    .q_vld    (q_vld),
    .q_cnt    (q_cnt)
  );

  dts_pick #(.DEPTH(DEPTH)) u_pick (
    .q_ent    (q_ent),
    .q_vld    (q_vld),
    .hint     (wr_first),
    .sel_idx  (sel_idx),
    .wr_found (wr_found)
  );

  dts_tenure #(.BURST_LEN(BURST_LEN)) u_tenure (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (qual_grant),
    .start_ent    (q_ent[sel_idx]),
    .xfer_ack     (xfer_ack),
    .data_retry   (data_retry),
    .idle         (ten_idle),
    .busy_n       (busy_n),
    .act_ent      (act_ent),
    .retire_valid (retire_valid),
    .retire_tag   (retire_tag)
  );

  assign act_valid = !ten_idle;
  assign act_write = act_ent.write;
  assign act_tag   = act_ent.tag;

  // Checker-side view: any write older than the chosen slot, any write at all.
  logic earlier_wr;
  logic any_wr;
  always_comb begin
    earlier_wr = 1'b0;
    any_wr     = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (q_vld[i] && q_ent[i].write) begin
        any_wr = 1'b1;
        if (IDX_W'(i) < sel_idx) earlier_wr = 1'b1;
      end
    end
  end

  AST_HINT_OFF_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_grant && !wr_first) |-> (sel_idx == '0)); // R2

  AST_HINT_TAKES_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_grant && wr_first && any_wr) |=> act_write); // R3

  AST_WR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_grant && q_ent[sel_idx].write) |-> !earlier_wr); // R4

  AST_HINT_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_grant && wr_first && !any_wr) |-> (sel_idx == '0)); // R5

  AST_BLOCKED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (ten_idle && ext_busy) |=> busy_n); // R7

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && push_valid && !qual_grant) |=> q_full); // R11

endmodule

// File: tb/test_dts_sched.sv
`timescale 1ns/1ps
module test_dts_sched;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       push_valid, push_write, push_burst;
  logic [3:0] push_tag;
  logic       q_full, grant, ext_busy, wr_first, xfer_ack, data_retry;
  logic       busy_n, act_valid, act_write, retire_valid;
  logic [3:0] act_tag, retire_tag;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #10 clk = ~clk;

  dts_sched i_dts_sched (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_write(push_write), .push_burst(push_burst),
    .push_tag(push_tag), .q_full(q_full),
    .grant(grant), .ext_busy(ext_busy), .wr_first(wr_first),
    .xfer_ack(xfer_ack), .data_retry(data_retry),
    .busy_n(busy_n), .act_valid(act_valid), .act_write(act_write),
    .act_tag(act_tag), .retire_valid(retire_valid), .retire_tag(retire_tag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_push(input int tag, input bit wr, input bit bst);
    @(negedge clk);
    push_valid = 1'b1; push_write = wr; push_burst = bst; push_tag = 4'(tag);
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  // Entered just after the grant edge, owner state visible.
  task automatic finish_beats(input int tag, input bit bst, input string req);
    int n;
    n = bst ? 4 : 1;
    for (int k = 0; k < n; k++) begin
      xfer_ack = 1'b1;
      @(negedge clk);
      xfer_ack = 1'b0;
      #1;
      if (k < n - 1) begin
        chk("R8", "retire_valid mid-burst", int'(retire_valid), 0);
        chk("R8", "busy_n mid-burst", int'(busy_n), 0);
      end
    end
    chk(req, "retire_valid", int'(retire_valid), 1);
    chk(req, "retire_tag", int'(retire_tag), tag);
    @(negedge clk); #1;
    chk("R10", "busy_n after retire", int'(busy_n), 1);
  endtask

  task automatic run_tenure(input int tag, input bit wr, input bit bst,
                            input bit hint, input string req);
    @(negedge clk);
    grant = 1'b1; wr_first = hint;
    @(negedge clk);
    grant = 1'b0; wr_first = 1'b0;
    #1;
    chk("R7", "busy_n after grant", int'(busy_n), 0);
    chk(req, "act_tag", int'(act_tag), tag);
    chk(req, "act_write", int'(act_write), int'(wr));
    finish_beats(tag, bst, "R8");
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "busy_n", int'(busy_n), 1);
    chk("R1", "q_full", int'(q_full), 0);
    chk("R1", "retire_valid", int'(retire_valid), 0);
    chk("R1", "act_valid", int'(act_valid), 0);
  endtask

  task automatic t_fifo;
    do_push(1, 1'b0, 1'b0);
    do_push(2, 1'b1, 1'b1);
    do_push(3, 1'b0, 1'b1);
    run_tenure(1, 1'b0, 1'b0, 1'b0, "R2");
    run_tenure(2, 1'b1, 1'b1, 1'b0, "R2");
    run_tenure(3, 1'b0, 1'b1, 1'b0, "R2");
  endtask

  task automatic t_hint;
    do_push(4, 1'b0, 1'b0);
    do_push(5, 1'b0, 1'b0);
    do_push(6, 1'b1, 1'b0);
    do_push(7, 1'b1, 1'b1);
    run_tenure(6, 1'b1, 1'b0, 1'b1, "R3");
    run_tenure(7, 1'b1, 1'b1, 1'b1, "R4");
    run_tenure(4, 1'b0, 1'b0, 1'b1, "R5");
    run_tenure(5, 1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_sample;
    do_push(8, 1'b0, 1'b0);
    do_push(9, 1'b1, 1'b0);
    @(negedge clk);
    grant = 1'b1; ext_busy = 1'b1; wr_first = 1'b1;
    @(negedge clk); #1;
    chk("R7", "busy_n while ext_busy", int'(busy_n), 1);
    ext_busy = 1'b0; wr_first = 1'b0;
    @(negedge clk);
    grant = 1'b0; wr_first = 1'b1;
    #1;
    chk("R6", "act_tag hint off at grant", int'(act_tag), 8);
    chk("R7", "busy_n after grant", int'(busy_n), 0);
    finish_beats(8, 1'b0, "R6");
    wr_first = 1'b0;
    run_tenure(9, 1'b1, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_retry;
    do_push(10, 1'b1, 1'b0);
    @(negedge clk);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    xfer_ack = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0;
    data_retry = 1'b1;
    #1;
    chk("R9", "retire_valid under retry", int'(retire_valid), 0);
    @(negedge clk);
    data_retry = 1'b0;
    #1;
    chk("R9", "busy_n after retry", int'(busy_n), 0);
    @(negedge clk); @(negedge clk); #1;
    chk("R9", "busy_n waiting", int'(busy_n), 0);
    chk("R9", "retire_valid waiting", int'(retire_valid), 0);
    finish_beats(10, 1'b0, "R9");
  endtask

  task automatic t_empty;
    @(negedge clk);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    #1;
    chk("R10", "busy_n grant on empty", int'(busy_n), 1);
  endtask

  task automatic t_full;
    for (int t = 11; t < 15; t++) do_push(t, 1'b0, 1'b0);
    #1;
    chk("R11", "q_full at 4", int'(q_full), 1);
    do_push(15, 1'b1, 1'b0);
    for (int t = 11; t < 15; t++) run_tenure(t, 1'b0, 1'b0, 1'b1, "R11");
    #1;
    chk("R11", "q_full drained", int'(q_full), 0);
    @(negedge clk);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    #1;
    chk("R11", "dropped push not queued", int'(busy_n), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    push_valid = 1'b0; push_write = 1'b0; push_burst = 1'b0; push_tag = '0;
    grant = 1'b0; ext_busy = 1'b0; wr_first = 1'b0;
    xfer_ack = 1'b0; data_retry = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fifo();
    t_hint();
    t_sample();
    t_retry();
    t_empty();
    t_full();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule